// File: doc/BRIEF.md
# Packed ADC Sample Capture Buffer

This block records a burst of 10-bit converter samples into on-chip storage. Software first sets how many samples it wants, then arms the block. The first trigger pulse seen while armed opens the capture window. Each accepted sample after the trigger is packed into a 32-bit word that holds three samples, and each completed word is written into an internal FIFO. The capture stops when the programmed count or the FIFO's reported capacity is reached, whichever is smaller. If the last sample does not complete a word, that word is written with its empty slots zeroed. Software then drains the words one at a time through a read strobe and reads back how many samples are valid.

The FIFO is built with a few guard words beyond its reported capacity, so its reported size is a guaranteed minimum. The capacity in samples is `(FIFO_DEPTH - GUARD_WORDS) * 3`. A configuration with 8196 words and 5 guard words reports 24573 (0x5FFD) samples and physically holds 24588. The default parameters are kept smaller so the block elaborates quickly.

The control is one state machine with four states:
- `ST_IDLE`: after reset. `arm` takes it to `ST_ARMED`.
- `ST_ARMED`: waiting for a trigger. `arm` restarts the wait and latches the limit again. `trig` goes to `ST_CAPTURE`, or straight to `ST_DONE` when the effective limit is zero.
- `ST_CAPTURE`: accepting samples. Accepting the sample that reaches the limit goes to `ST_DONE`.
- `ST_DONE`: results held. `arm` goes to `ST_ARMED`.

Top module: `sample_pack_capture`

## Requirements
- R1: In each FIFO word, the earliest sample of the three is in bits [9:0], the next in bits [19:10] and the last in bits [29:20]. Bits [31:30] are always zero.
- R2: The sample-limit register is at register address 16 and can be written and read back. After reset it reads the reported capacity, `(FIFO_DEPTH - GUARD_WORDS) * 3`.
- R3: A capture stores exactly min(limit register, capacity) samples. A larger written value (for example 50000) still stops at the capacity. The limit is taken when `arm` is accepted.
- R4: A smaller limit stores fewer samples. A limit of zero ends the capture at the trigger and stores no words.
- R5: When the final sample leaves a word incomplete, that word is still written, with its unused slots zero. Register address 17 reads the number of valid samples stored in the current run. Other register addresses read zero.
- R6: Sampling begins with the first `smp_valid` cycle after the trigger cycle; the sample presented in the trigger cycle itself is not stored. A trigger is ignored when the block is not armed or is already capturing.
- R7: `done` rises in the cycle after the last counted sample is accepted. It stays high until `arm` is accepted, and then clears. `arm` is ignored during `ST_CAPTURE`.
- R8: Samples offered after the limit is reached are dropped. The FIFO is never written while full, and stored words are never overwritten.
- R9: `rd_data` shows the oldest stored word whenever `rd_empty` is low. Each cycle with `rd_en` high removes exactly one word. A read strobe while empty has no effect.
- R10: Accepting `arm` empties the FIFO, resets the valid-sample count to zero and clears any partly packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Arm pulse (ignored while capturing) |
| trig | input | 1 | Trigger, acted on only while armed |
| smp_valid | input | 1 | A sample is present on smp_data this cycle |
| smp_data | input | SAMPLE_W | Converter sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| rd_en | input | 1 | Pop one word from the FIFO |
| rd_data | output | WORD_W | Oldest stored word |
| rd_empty | output | 1 | No stored words remain |
| armed | output | 1 | In ST_ARMED |
| capturing | output | 1 | In ST_CAPTURE |
| done | output | 1 | In ST_DONE |

## Verification
On every cycle, the assertions check that the FIFO is never written while full and that a written word has zero padding. They also check that the valid count never passes the capacity, that a trigger outside the armed state never starts a capture, that `done` stays high until it is re-armed and clears when it is, and that a read strobe on an empty FIFO leaves it empty. Only the bench scenarios can show that the stored words hold the right samples in the right slots, and that the count stops at min(limit, capacity). To do so, the bench sweeps every limit from zero past the capacity of a small 8-word FIFO and drains the result. The same scenarios cover the sample in the trigger cycle being skipped, and an `arm` pulse during a capture changing nothing.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

    function automatic int cap_samples(input int depth, input int guard, input int lanes);
        return (depth - guard) * lanes;
    endfunction

endpackage

// File: rtl/sp_packer.sv
module sp_packer #(
    parameter int SAMPLE_W = 10,
    parameter int LANES    = 3,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take,
    input  logic                last,
    input  logic [SAMPLE_W-1:0] din,
    output logic                push,
    output logic [WORD_W-1:0]   word
);
    localparam int LW  = $clog2(LANES);
    localparam int PAD = WORD_W - LANES * SAMPLE_W;

    logic [LW-1:0]       lane;
    logic [SAMPLE_W-1:0] slot [LANES];

    // Slot g carries the incoming sample when it is the current lane,
    // the held sample when earlier, and zero when still unfilled.
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        assign word[g*SAMPLE_W +: SAMPLE_W] =
            (LW'(g) == lane) ? din :
            (LW'(g) <  lane) ? slot[g] : '0;
    end

    if (PAD > 0) begin : g_pad
        assign word[WORD_W-1 -: PAD] = '0;
    end

    assign push = take && ((lane == LW'(LANES - 1)) || last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane <= '0;
            for (int i = 0; i < LANES; i++) slot[i] <= '0;
        end else if (clr || push) begin
            lane <= '0;
            for (int i = 0; i < LANES; i++) slot[i] <= '0;
        end else if (take) begin
            slot[lane] <= din;
            lane       <= lane + 1'b1;
        end
    end

endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);
    localparam int OW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [OW-1:0]    occ;
    logic             do_push, do_pop;

    assign empty   = (occ == '0);
    assign full    = (occ == OW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            occ <= occ + OW'(do_push) - OW'(do_pop);
        end
    end

endmodule

// File: rtl/sp_regs.sv
module sp_regs #(
    parameter int REG_AW   = 5,
    parameter int REG_W    = 16,
    parameter int CNT_W    = 10,
    parameter int LIM_ADDR = 16,
    parameter int CNT_ADDR = 17,
    parameter int RST_LIM  = 765
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  vcount,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  limit <= REG_W'(RST_LIM);
        else if (wr && addr == REG_AW'(LIM_ADDR))    limit <= wdata;
    end

    always_comb begin
        if (addr == REG_AW'(LIM_ADDR))      rdata = limit;
        else if (addr == REG_AW'(CNT_ADDR)) rdata = REG_W'(vcount);
        else                                rdata = '0;
    end

endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
    import sp_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig,
    input  logic             smp_valid,
    input  logic             fifo_full,
    input  logic [CNT_W-1:0] lim_in,
    output logic             clr,
    output logic             take,
    output logic             last,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             capturing,
    output logic             done
);
    cap_state_t       state, state_nx;
    logic [CNT_W-1:0] lim_q;
    logic             arm_ok;

    assign arm_ok = arm && (state != ST_CAPTURE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (arm) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (arm)       state_nx = ST_ARMED;
                else if (trig) state_nx = (lim_q == '0) ? ST_DONE : ST_CAPTURE;
            end
            ST_CAPTURE: if (last) state_nx = ST_DONE;
            ST_DONE:    if (arm)  state_nx = ST_ARMED;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        armed     = (state == ST_ARMED);
        capturing = (state == ST_CAPTURE);
        done      = (state == ST_DONE);
        clr       = arm_ok;
        take      = capturing && smp_valid && !fifo_full && (count < lim_q);
        last      = take && ((count + CNT_W'(1)) == lim_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
            count <= '0;
        end else if (arm_ok) begin
            lim_q <= lim_in;
            count <= '0;
        end else if (take) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sample_pack_capture.sv
module sample_pack_capture
    import sp_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int LANES       = 3,
    parameter int WORD_W      = 32,
    parameter int FIFO_DEPTH  = 256,
    parameter int GUARD_WORDS = 1,
    parameter int REG_AW      = 5,
    parameter int REG_W       = 16,
    parameter int LIM_ADDR    = 16,
    parameter int CNT_ADDR    = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                trig,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_empty,
    output logic                armed,
    output logic                capturing,
    output logic                done
);
    localparam int CAP_SAMPLES = cap_samples(FIFO_DEPTH, GUARD_WORDS, LANES);
    localparam int CNT_W       = $clog2(CAP_SAMPLES + 1);

    logic [REG_W-1:0]  lim_reg;
    logic [CNT_W-1:0]  eff_lim, count;
    logic              clr, take, last, pk_push, ff_full;
    logic [WORD_W-1:0] pk_word;

    // Effective stop point: the smaller of the register and the capacity
    assign eff_lim = (lim_reg > REG_W'(CAP_SAMPLES)) ? CNT_W'(CAP_SAMPLES)
                                                     : lim_reg[CNT_W-1:0];

    sp_regs #(
        .REG_AW(REG_AW), .REG_W(REG_W), .CNT_W(CNT_W),
        .LIM_ADDR(LIM_ADDR), .CNT_ADDR(CNT_ADDR), .RST_LIM(CAP_SAMPLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .vcount(count), .rdata(reg_rdata), .limit(lim_reg)
    );

    sp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
        .smp_valid(smp_valid), .fifo_full(ff_full), .lim_in(eff_lim),
        .clr(clr), .take(take), .last(last), .count(count),
        .armed(armed), .capturing(capturing), .done(done)
    );

    sp_packer #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .last(last),
        .din(smp_data), .push(pk_push), .word(pk_word)
    );

    sp_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(pk_push), .din(pk_word),
        .pop(rd_en), .dout(rd_data), .empty(rd_empty), .full(ff_full)
    );

endmodule

// File: rtl/sp_capture_chk.sv
module sp_capture_chk #(
    parameter int WORD_W      = 32,
    parameter int USED_W      = 30,
    parameter int CNT_W       = 10,
    parameter int CAP_SAMPLES = 765
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              trig,
    input logic              rd_en,
    input logic              rd_empty,
    input logic              armed,
    input logic              capturing,
    input logic              done,
    input logic              push,
    input logic              full,
    input logic [WORD_W-1:0] word,
    input logic [CNT_W-1:0]  count
);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (word[WORD_W-1:USED_W] == '0));

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CAP_SAMPLES));

    assert_trig_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !capturing && trig) |=> !capturing);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arm) |=> (!done && armed));

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && rd_en && !push) |=> rd_empty);

endmodule

bind sample_pack_capture sp_capture_chk #(
    .WORD_W(WORD_W), .USED_W(LANES * SAMPLE_W),
    .CNT_W(CNT_W), .CAP_SAMPLES(CAP_SAMPLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .rd_en(rd_en),
    .rd_empty(rd_empty), .armed(armed), .capturing(capturing), .done(done),
    .push(pk_push), .full(ff_full), .word(pk_word), .count(count)
);

// File: tb/sample_pack_capture_tb.sv
`timescale 1ns/1ps
module sample_pack_capture_tb;
    localparam int DEPTH = 8;
    localparam int GUARD = 1;
    localparam int CAP   = (DEPTH - GUARD) * 3;   // 21 samples

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 0, trig = 0, smp_valid = 0, reg_wr = 0, rd_en = 0;
    logic [9:0]  smp_data = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] rd_data;
    logic        rd_empty, armed, capturing, done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sample_pack_capture #(.FIFO_DEPTH(DEPTH), .GUARD_WORDS(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
        .smp_valid(smp_valid), .smp_data(smp_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .armed(armed), .capturing(capturing), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int smp(input int run, input int k);
        return (run * 97 + k * 29 + 3) % 1024;
    endfunction

    task automatic reg_write(input int a, input int v);
        @(negedge clk); reg_wr = 1; reg_addr = 5'(a); reg_wdata = 16'(v);
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic reg_read(input int a, output int v);
        @(negedge clk); reg_addr = 5'(a); #1; v = int'(reg_rdata);
    endtask

    task automatic run_capture(input int run, input int lim, input bit arm_mid);
        int e, nw, v, k, cyc;
        e = (lim < CAP) ? lim : CAP;
        reg_write(16, lim);
        reg_read(16, v);
        chk("R2 limit readback", v, lim);
        @(negedge clk); arm = 1;
        @(negedge clk); arm = 0;
        chk("R7 armed after arm", armed, 1);
        chk("R7 done cleared by arm", done, 0);
        chk("R10 fifo empty after arm", rd_empty, 1);
        reg_read(17, v);
        chk("R10 count cleared by arm", v, 0);
        // trigger cycle carries a sample that must not be stored
        trig = 1; smp_valid = 1; smp_data = 10'h3FF;
        @(negedge clk); trig = 0; smp_valid = 0;
        if (e == 0) chk("R4 zero limit done at trigger", done, 1);
        else        chk("R6 capturing after trigger", capturing, 1);
        k = 0; cyc = 0;
        while (k < e + 4) begin
            smp_valid = (cyc % 4 != 3);
            trig = (cyc == 2);           // trigger during capture: ignored
            arm  = arm_mid && (k == 1);  // arm during capture: ignored
            if (smp_valid) begin smp_data = 10'(smp(run, k)); k++; end
            cyc++;
            @(negedge clk);
        end
        smp_valid = 0; trig = 0; arm = 0;
        @(negedge clk);
        chk("R7 done after limit", done, 1);
        chk("R7 not capturing after limit", capturing, 0);
        reg_read(17, v);
        chk("R3 R5 valid count", v, e);
        nw = (e + 2) / 3;
        for (int j = 0; j < nw; j++) begin
            logic [31:0] exp_w;
            exp_w = '0;
            for (int i = 0; i < 3; i++)
                if (3 * j + i < e) exp_w[i*10 +: 10] = 10'(smp(run, 3 * j + i));
            chk("R9 not empty before drain", rd_empty, 0);
            chk("R1 R5 R6 word contents", rd_data, exp_w);
            rd_en = 1;
            @(negedge clk);
            rd_en = 0;
        end
        chk("R8 R9 empty after expected words", rd_empty, 1);
        rd_en = 1;
        @(negedge clk); rd_en = 0;
        chk("R9 pop on empty stays empty", rd_empty, 1);
        chk("R7 done held", done, 1);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 empty at reset", rd_empty, 1);
        chk("R7 done low at reset", done, 0);
        chk("R6 not armed at reset", armed, 0);
        reg_read(16, v);
        chk("R2 reset limit equals capacity", v, CAP);
        reg_read(17, v);
        chk("R5 count zero at reset", v, 0);
        reg_read(5, v);
        chk("R5 unmapped address reads zero", v, 0);

        // trigger while idle: ignored
        @(negedge clk); trig = 1; smp_valid = 1; smp_data = 10'h155;
        for (int i = 0; i < 5; i++) begin @(negedge clk); trig = 0; end
        smp_valid = 0;
        chk("R6 idle trigger no capture", capturing, 0);
        chk("R6 idle trigger fifo empty", rd_empty, 1);

        // sweep every limit from zero to past capacity
        for (int l = 0; l <= CAP + 3; l++) run_capture(l, l, 1'b0);
        run_capture(40, 50000, 1'b0);
        run_capture(41, 7, 1'b1);
        run_capture(42, 20, 1'b1);

        // trigger in done state: ignored
        @(negedge clk); trig = 1; smp_valid = 1;
        @(negedge clk); trig = 0;
        repeat (4) @(negedge clk);
        smp_valid = 0;
        chk("R6 trigger in done ignored", rd_empty, 1);
        reg_read(17, v);
        chk("R6 count unchanged in done", v, 20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule